// File: doc/BRIEF.md
# Unaligned Load Data Aligner

This block sits on the load return path of a 32-bit processor. Memory hands back the aligned 32-bit word that contains the requested data. The block turns that word into the value written to the destination register. The inputs that decide the result are the access size, whether the load is signed, and the two low address bits.

Misaligned accesses do not fault. A word load at a misaligned address rotates the aligned word. A halfword load at an odd address rotates the aligned halfword into the top and bottom bytes. A signed halfword load at an odd address falls back to a sign-extended byte load.

The datapath is combinational. A parameter selects an output register; with it, a valid strobe travels alongside the data with a fixed latency of one cycle.

Top module: `load_aligner`

## Requirements
- R1: A word load (size code 2'b10) returns the raw word rotated right by 8 times the low address bits, so result byte k is raw byte (k + addrLo) mod 4, where raw byte 0 is bits 7:0.
- R2: An unsigned halfword load (size code 2'b01) at an even address returns the halfword in raw bits 15:0 (addrLo 0) or raw bits 31:16 (addrLo 2), zero-extended.
- R3: A signed halfword load at an even address returns the same halfword sign-extended from its bit 15.
- R4: An unsigned halfword load at an odd address uses the halfword at the address rounded down to even. It returns that halfword's low byte in bits 31:24, its high byte in bits 7:0, and zeros in bits 23:8.
- R5: A signed halfword load at an odd address returns the byte at the exact address (the high byte of the even-rounded halfword), sign-extended from bit 7.
- R6: An unsigned byte load (size code 2'b00) returns raw byte addrLo zero-extended.
- R7: A signed byte load returns raw byte addrLo sign-extended from bit 7.
- R8: The signed flag has no effect on word loads.
- R9: Size code 2'b11 behaves as a word load.
- R10: With the output register enabled (REG_OUT=1), an accepted input appears on outData with outValid high exactly one cycle later. outValid is low in any cycle after a cycle with inValid low. Reset clears outValid and outData to 0.
- R11: With the output register enabled, outData holds its value across cycles with inValid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word and controls are valid this cycle |
| inSize | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| inSigned | input | 1 | Sign-extend the loaded value |
| inAddrLo | input | 2 | Low two bits of the load address |
| inData | input | 32 | Aligned raw word from memory, little-endian |
| outValid | output | 1 | Result valid |
| outData | output | 32 | Aligned, extended register value |

## Verification
The assertions assume the registered variant. They also assume that inSize, inSigned, inAddrLo and inData are meaningful only in cycles where inValid is high, and that inValid is held low throughout reset. The stimulus meets this by holding inValid low during reset and then driving every combination of size, sign and address offset over several data patterns. Those patterns include sign bits set and cleared in each byte lane. Idle cycles with changing junk on the data inputs are mixed in, to confirm the held output.

// File: rtl/load_align_pkg.sv
package load_align_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int LANES   = DATA_W / BYTE_W;
  localparam int LANE_AW = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  typedef enum logic [2:0] {
    EXT_PASS,
    EXT_ZERO8,
    EXT_SIGN8,
    EXT_ZERO16,
    EXT_SIGN16,
    EXT_SPLIT
  } extMode_e;

  typedef struct packed {
    logic [LANE_AW-1:0] rotLanes;
    extMode_e           extMode;
  } alignCtl_t;
endpackage

// File: rtl/load_align_ctrl.sv
module load_align_ctrl
  import load_align_pkg::*;
(
  input  logic [1:0]         size,
  input  logic               isSigned,
  input  logic [LANE_AW-1:0] addrLo,
  output alignCtl_t          ctl
);
  always_comb begin
    ctl.rotLanes = addrLo;
    unique case (accSize_e'(size))
      SZ_BYTE: ctl.extMode = isSigned ? EXT_SIGN8 : EXT_ZERO8;
      SZ_HALF: begin
        if (addrLo[0]) ctl.extMode = isSigned ? EXT_SIGN8 : EXT_SPLIT;
        else           ctl.extMode = isSigned ? EXT_SIGN16 : EXT_ZERO16;
      end
      default: ctl.extMode = EXT_PASS;
    endcase
  end
endmodule

// File: rtl/load_align_dp.sv
module load_align_dp
  import load_align_pkg::*;
(
  input  logic [DATA_W-1:0] rawData,
  input  alignCtl_t         ctl,
  output logic [DATA_W-1:0] result
);
  logic [BYTE_W-1:0] rotByte [LANES];
  logic [DATA_W-1:0] rotated;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [LANE_AW-1:0] kIdx = LANE_AW'(k);
    logic [LANE_AW-1:0] srcLane;
    assign srcLane    = kIdx + ctl.rotLanes;
    assign rotByte[k] = rawData[srcLane*BYTE_W +: BYTE_W];
    assign rotated[k*BYTE_W +: BYTE_W] = rotByte[k];
  end

  always_comb begin
    unique case (ctl.extMode)
      EXT_ZERO8:  result = {{(DATA_W-BYTE_W){1'b0}}, rotated[BYTE_W-1:0]};
      EXT_SIGN8:  result = {{(DATA_W-BYTE_W){rotated[BYTE_W-1]}}, rotated[BYTE_W-1:0]};
      EXT_ZERO16: result = {{(DATA_W-2*BYTE_W){1'b0}}, rotated[2*BYTE_W-1:0]};
      EXT_SIGN16: result = {{(DATA_W-2*BYTE_W){rotated[2*BYTE_W-1]}}, rotated[2*BYTE_W-1:0]};
      EXT_SPLIT:  result = {rotated[DATA_W-1 -: BYTE_W],
                            {(DATA_W-2*BYTE_W){1'b0}}, rotated[BYTE_W-1:0]};
      default:    result = rotated;
    endcase
  end
endmodule

// File: rtl/load_aligner.sv
module load_aligner
  import load_align_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inSize,
  input  logic              inSigned,
  input  logic [1:0]        inAddrLo,
  input  logic [31:0]       inData,
  output logic              outValid,
  output logic [31:0]       outData
);
  alignCtl_t         ctl;
  logic [DATA_W-1:0] aligned;

  load_align_ctrl u_ctrl (
    .size(inSize), .isSigned(inSigned), .addrLo(inAddrLo), .ctl(ctl)
  );

  load_align_dp u_dp (
    .rawData(inData), .ctl(ctl), .result(aligned)
  );

  if (REG_OUT) begin : g_reg
    logic              validQ;
    logic [DATA_W-1:0] dataQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
        dataQ  <= '0;
      end else begin
        validQ <= inValid;
        if (inValid) dataQ <= aligned;
      end
    end
    assign outValid = validQ;
    assign outData  = dataQ;
  end else begin : g_comb
    assign outValid = inValid;
    assign outData  = aligned;
  end
endmodule

// File: rtl/load_aligner_chk.sv
module load_aligner_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [1:0]  inSize,
  input logic        inSigned,
  input logic [1:0]  inAddrLo,
  input logic [31:0] inData,
  input logic        outValid,
  input logic [31:0] outData
);
  if (REG_OUT) begin : g_chk
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> $stable(outData));
    assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inSize[1] && inAddrLo == 2'd0) |=> outData == $past(inData));
    assert_half_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inSize == 2'b01 && !inSigned && !inAddrLo[0]) |=> outData[31:16] == 16'h0);
    assert_half_split_R4: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inSize == 2'b01 && !inSigned && inAddrLo[0]) |=> outData[23:8] == 16'h0);
    assert_byte_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inSize == 2'b00 && !inSigned) |=> outData[31:8] == 24'h0);
    assert_byte_sign_R7: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inSize == 2'b00 && inSigned) |=> outData[31:8] == {24{outData[7]}});
  end
endmodule

bind load_aligner load_aligner_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_load_aligner.sv
module tb_load_aligner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inSize = 2'b00;
  logic        inSigned = 1'b0;
  logic [1:0]  inAddrLo = 2'b00;
  logic [31:0] inData = 32'h0;
  logic        outValid;
  logic [31:0] outData;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] val; string tag; } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  load_aligner #(.REG_OUT(1'b1)) dut (.*);

  function automatic logic [7:0] rawByte(logic [31:0] d, int idx);
    return d[8*(idx % 4) +: 8];
  endfunction

  function automatic item_t model(logic [1:0] sz, logic sg, logic [1:0] a, logic [31:0] d);
    item_t it;
    logic [15:0] hw;
    logic [7:0]  b;
    hw = a[1] ? d[31:16] : d[15:0];
    b  = rawByte(d, a);
    if (sz[1]) begin
      for (int k = 0; k < 4; k++) it.val[8*k +: 8] = rawByte(d, k + a);
      it.tag = (sz == 2'b11) ? "R9" : (sg ? "R8" : "R1");
    end else if (sz == 2'b01) begin
      if (!a[0]) begin
        it.val = sg ? {{16{hw[15]}}, hw} : {16'h0, hw};
        it.tag = sg ? "R3" : "R2";
      end else begin
        it.val = sg ? {{24{hw[15]}}, hw[15:8]} : {hw[7:0], 16'h0, hw[15:8]};
        it.tag = sg ? "R5" : "R4";
      end
    end else begin
      it.val = sg ? {{24{b[7]}}, b} : {24'h0, b};
      it.tag = sg ? "R7" : "R6";
    end
    return it;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] sz, logic sg, logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    inValid = 1'b1; inSize = sz; inSigned = sg; inAddrLo = a; inData = d;
    expQ.push_back(model(sz, sg, a, d));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      inValid = 1'b0; inData = 32'hDEAD_0000 | 32'(i); inSize = 2'(i); inSigned = i[0];
    end
  endtask

  // Monitor: samples at the falling edge, pops one expected item per valid output.
  logic [31:0] lastOut = 32'h0;
  bit          seenOut = 1'b0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) check(1'b0, "R10 unexpected outValid", outData, 32'h0);
        else begin
          item_t it;
          it = expQ.pop_front();
          check(outData === it.val, it.tag, outData, it.val);
        end
        lastOut = outData;
        seenOut = 1'b1;
      end else if (seenOut) begin
        check(outData === lastOut, "R11 hold while idle", outData, lastOut);
      end
    end
  end

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'h8070_F011; pats[1] = 32'h7F80_01FE; pats[2] = 32'hA5B6_C7D8;
    pats[3] = 32'h1234_5678; pats[4] = 32'hFF00_80FF;
    repeat (3) @(posedge clk);
    #1;
    check(outValid === 1'b0, "R10 reset outValid", 32'(outValid), 32'h0);
    check(outData === 32'h0, "R10 reset outData", outData, 32'h0);
    rstN = 1'b1;
    idle(2);
    check(outValid === 1'b0, "R10 idle outValid", 32'(outValid), 32'h0);
    foreach (pats[p]) begin
      for (int s = 0; s < 4; s++)
        for (int g = 0; g < 2; g++)
          for (int a = 0; a < 4; a++) begin
            drive(2'(s), g[0], 2'(a), pats[p]);
            if (((s + a + g) % 5) == 0) idle(2);
          end
    end
    // named corner cases
    drive(2'b10, 1'b0, 2'd1, 32'h4433_2211); // R1 rotate by 8 -> 11443322
    drive(2'b01, 1'b0, 2'd3, 32'hBBAA_0000); // R4 -> AA0000BB
    drive(2'b01, 1'b1, 2'd1, 32'h0000_80FF); // R5 -> FFFFFF80
    drive(2'b01, 1'b1, 2'd2, 32'h8001_0000); // R3 -> FFFF8001
    drive(2'b00, 1'b1, 2'd3, 32'h7F00_0000); // R7 -> 0000007F
    idle(3);
    check(outValid === 1'b0, "R10 valid drops after idle", 32'(outValid), 32'h0);
    check(expQ.size() == 0, "R10 queue drained", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule